// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial EEPROM. It watches oversampled clock and data lines and finds START, repeated START and STOP conditions. It acknowledges a 7-bit device address made of a fixed type nibble and three strap inputs. After a write address it takes a 16-bit word address, high byte first. It then either collects data bytes into a one-page staging buffer or, after a repeated START with the read bit set, streams bytes from the array. The data line is never driven high: the block only pulls it low through an enable output.

A write transaction stops at the STOP condition. If the write-protect input is low at that moment, the bytes received are copied into the array and a fixed-length internal write cycle begins. During that cycle the slave answers no device address. A master can therefore poll with address bytes until the first ACK tells it the cycle has finished. The array size is a parameter (1024 bytes by default). Word address bits above the array width are ignored. Pages are 128 bytes.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The device address byte is acknowledged only when bits 7..4 are 1010b, bits 3..1 equal `strap[2:0]` and no write cycle is running. Bit 0 is the read flag (1 = read). A byte that does not match is not acknowledged, and nothing further is acknowledged until the next START or STOP.
- R2: After a write-flagged device address, two word-address bytes follow, high byte first, and set the address pointer. Only the low MEM_AW bits are kept (10 by default). Higher bits are ignored.
- R3: Data bytes of a write land at successive offsets. The 7-bit in-page offset wraps from 127 to 0 and the page number never changes, so bytes past the page end overwrite the start of the same page.
- R4: Only the offsets actually received are committed. Every other byte of the page, and of the array, keeps its value. A single-byte write behaves as a one-byte page write.
- R5: The write cycle begins at the STOP that ends a write transaction with at least one data byte. It lasts exactly WR_CYCLES clocks.
- R6: While the write cycle runs, no device address is acknowledged. The first address byte after it ends is acknowledged.
- R7: WP is sampled at that STOP. When WP is high, nothing is committed and no write cycle starts.
- R8: A read-flagged address with no word address returns the byte at the pointer. A random read is a dummy write of the two word-address bytes, then a repeated START and a read.
- R9: Each byte read or written advances the pointer. A read advances it modulo the array size, so the byte after the last address is address 0. A master NACK ends the read and releases the data line.
- R10: After reset every array byte reads FFh and the data line is released.
- R11: The data-line pull-low enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strap | input | 3 | Device address straps |
| wpIn | input | 1 | Write protect, active high |
| sdaPullLow | output | 1 | Pull the data line low when 1 |

## Verification
The acknowledge decision on a device address and the expiry of the write-cycle counter can fall in the same clock. The bench starts polling right after every committed write. Successive polls step the address-acknowledge cycle across the moment busy clears. The poll count and the cycles elapsed are then judged: the first ACK must not come before WR_CYCLES and must come within one poll after it. A STOP that commits while WP changes between transactions is also covered. Randomly protected writes must show no busy period and no change to the array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Fixed upper nibble of the device address
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  // Strobes from bus control to storage datapath (single-cycle)
  typedef struct packed {
    logic       clrBuf;    // START seen: discard staged bytes
    logic       setHi;     // word address high byte received
    logic       setLo;     // word address low byte received
    logic       putByte;   // write data byte received
    logic       nextRd;    // read byte shifted out
    logic       stopSeen;  // STOP seen
    logic [7:0] data;
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD
  } busState_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       busy,
  input  logic [7:0] rdData,
  output dpCmd_t     cmd,
  output logic       sdaPullLow
);

  logic [1:0] sclSync, sdaSync;
  logic       sclP, sdaP;
  logic       sclS, sdaS;
  logic       startDet, stopDet, sclRise, sclFall;

  busState_t  state;
  logic [3:0] bitCnt;
  logic       inAck;
  logic [7:0] shReg, txReg;
  logic       rwBit, masterAck, oeReg;
  logic       devHit;

  // two-stage synchronisers plus one history stage for edge detection (R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclSync[1];
      sdaP    <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;

  // R1, R6: type code, straps and idle array
  assign devHit = (shReg[7:4] == TYPE_CODE) && (shReg[3:1] == strap) && !busy;

  always_comb begin
    cmd          = '0;
    cmd.data     = shReg;
    cmd.clrBuf   = startDet;
    cmd.stopSeen = stopDet;
    if (!startDet && !stopDet && sclFall && !inAck && bitCnt == 4'd8) begin
      unique case (state)
        ST_AHI:  cmd.setHi   = 1'b1;
        ST_ALO:  cmd.setLo   = 1'b1;
        ST_WR:   cmd.putByte = 1'b1;
        ST_RD:   cmd.nextRd  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      shReg     <= '0;
      txReg     <= '0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
      oeReg     <= 1'b0;
    end else if (startDet) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      inAck  <= 1'b0;
      oeReg  <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      inAck <= 1'b0;
      oeReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RD: begin
          if (!inAck) begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                oeReg <= 1'b0;
                inAck <= 1'b1;
              end else begin
                oeReg <= ~txReg[3'd7 - bitCnt[2:0]];
              end
            end
          end else begin
            if (sclRise) masterAck <= ~sdaS;
            else if (sclFall) begin
              if (masterAck) begin   // R9: keep streaming
                txReg  <= rdData;
                oeReg  <= ~rdData[7];
                bitCnt <= '0;
                inAck  <= 1'b0;
              end else begin         // R9: NACK ends the read
                state <= ST_IDLE;
                inAck <= 1'b0;
                oeReg <= 1'b0;
              end
            end
          end
        end
        default: begin  // receiving states
          if (!inAck) begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (state != ST_DEV || devHit) begin
                oeReg <= 1'b1;
                inAck <= 1'b1;
                if (state == ST_DEV) rwBit <= shReg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end else if (sclFall) begin
            oeReg  <= 1'b0;
            inAck  <= 1'b0;
            bitCnt <= '0;
            unique case (state)
              ST_DEV: begin
                if (rwBit) begin
                  state <= ST_RD;
                  txReg <= rdData;
                  oeReg <= ~rdData[7];
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI:  state <= ST_ALO;
              ST_ALO:  state <= ST_WR;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign sdaPullLow = oeReg;

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int MEM_AW    = 10,
  parameter int PAGE_AW   = 7,
  parameter int WR_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       wpIn,
  output logic [7:0] rdData,
  output logic       busy
);

  localparam int MEM_BYTES  = 1 << MEM_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int HI_W       = MEM_AW - 8;
  localparam int CNT_W      = $clog2(WR_CYCLES + 1);

  logic [7:0]            mem [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufMask;
  logic [HI_W-1:0]       addrHi;
  logic [MEM_AW-1:0]     ptr;
  logic                  writeArm;
  logic [CNT_W-1:0]      busyCnt;
  logic                  commit;

  // R7: protect sampled only at the STOP that would start the cycle
  assign commit = cmd.stopSeen && writeArm && !wpIn && !busy;
  assign busy   = (busyCnt != '0);
  assign rdData = mem[ptr];

  // one staging lane per page offset (R3, R4)
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic [7:0] laneByte;
    logic       laneValid;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneByte  <= '0;
        laneValid <= 1'b0;
      end else if (cmd.clrBuf || cmd.stopSeen) begin
        laneValid <= 1'b0;
      end else if (cmd.putByte && ptr[PAGE_AW-1:0] == PAGE_AW'(g)) begin
        laneByte  <= cmd.data;
        laneValid <= 1'b1;
      end
    end
    assign pageBuf[g]  = laneByte;
    assign bufMask[g]  = laneValid;
  end

  // address pointer (R2, R3, R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi   <= '0;
      ptr      <= '0;
      writeArm <= 1'b0;
    end else begin
      if (cmd.setHi) addrHi <= cmd.data[HI_W-1:0];
      if (cmd.setLo) ptr <= {addrHi, cmd.data};
      else if (cmd.putByte)
        ptr <= {ptr[MEM_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};
      else if (cmd.nextRd)
        ptr <= ptr + 1'b1;
      if (cmd.clrBuf || cmd.stopSeen) writeArm <= 1'b0;
      else if (cmd.putByte)           writeArm <= 1'b1;
    end
  end

  // array: erased at reset (R10), masked page copy at commit (R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (bufMask[i]) mem[{ptr[MEM_AW-1:PAGE_AW], PAGE_AW'(i)}] <= pageBuf[i];
    end
  end

  // self-timed write cycle (R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyCnt <= '0;
    else if (commit)    busyCnt <= CNT_W'(WR_CYCLES);
    else if (busy)      busyCnt <= busyCnt - 1'b1;
  end

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_AW    = 10,
  parameter int PAGE_AW   = 7,
  parameter int WR_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       wpIn,
  output logic       sdaPullLow
);

  dpCmd_t     cmd;
  logic       cycleBusy;
  logic [7:0] rdData;

  eeprom_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .strap      (strap),
    .busy       (cycleBusy),
    .rdData     (rdData),
    .cmd        (cmd),
    .sdaPullLow (sdaPullLow)
  );

  eeprom_datapath #(
    .MEM_AW    (MEM_AW),
    .PAGE_AW   (PAGE_AW),
    .WR_CYCLES (WR_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wpIn   (wpIn),
    .rdData (rdData),
    .busy   (cycleBusy)
  );

endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
  parameter int WR_CYCLES = 500000
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic wpIn,
  input logic sdaPullLow,
  input logic busy
);

  logic [31:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 32'd1;
    else           busyLen <= '0;
  end

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);

  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaPullLow);

  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wpIn));

  p_cycle_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 32'(WR_CYCLES)));

endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .wpIn       (wpIn),
  .sdaPullLow (sdaPullLow),
  .busy       (cycleBusy)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;

  localparam int MEM_AW    = 10;
  localparam int PAGE_AW   = 7;
  localparam int WR_CYC    = 600;
  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int Q         = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wpM  = 1'b0;
  logic sdaPullLow;
  wire  sdaBus = sdaM & ~sdaPullLow;

  int tests = 0;
  int fails = 0;
  int oeViol = 0;
  longint cycCnt = 0;
  logic prevOe = 1'b0;
  logic done = 1'b0;

  logic [7:0]        model [MEM_BYTES];
  logic [7:0]        wrBuf [16];
  logic [MEM_AW-1:0] modelPtr = '0;

  always #5 clk = ~clk;

  eeprom_i2c_slave #(
    .MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYC)
  ) u_eeprom_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .strap(STRAP), .wpIn(wpM), .sdaPullLow(sdaPullLow)
  );

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // R11: pull-enable must only move while the clock line is low
  always @(negedge clk) begin
    if (rstN && sdaPullLow !== prevOe && sclM) oeViol++;
    prevOe = sdaPullLow;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitq(); sclM = 1'b1; waitq();
    sdaM = 1'b0; waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitq(); sclM = 1'b1; waitq();
    sdaM = 1'b1; waitq(); waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitq(); sclM = 1'b1; waitq(); waitq(); sclM = 1'b0; waitq();
    end
    sdaM = 1'b1; waitq(); sclM = 1'b1; waitq();
    ack = !sdaBus;
    waitq(); sclM = 1'b0; waitq();
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitq(); sclM = 1'b1; waitq();
      b = {b[6:0], sdaBus};
      waitq(); sclM = 1'b0;
    end
    waitq(); sdaM = !giveAck; waitq(); sclM = 1'b1; waitq(); waitq();
    sclM = 1'b0; waitq(); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic doWrite(input logic [15:0] a, input int n);
    logic ack;
    logic [MEM_AW-1:0] base;
    base = a[MEM_AW-1:0];
    i2cStart();
    sendByte(devByte(1'b0), ack);
    chk("R1 write address ack", ack, 1);
    sendByte(a[15:8], ack);
    sendByte(a[7:0], ack);
    for (int k = 0; k < n; k++) sendByte(wrBuf[k], ack);
    i2cStop();
    for (int k = 0; k < n; k++)
      if (!wpM)
        model[{base[MEM_AW-1:PAGE_AW], PAGE_AW'(int'(base[PAGE_AW-1:0]) + k)}] = wrBuf[k];
    modelPtr = {base[MEM_AW-1:PAGE_AW], PAGE_AW'(int'(base[PAGE_AW-1:0]) + n)};
  endtask

  task automatic waitReady(output int polls, output longint cycles);
    logic ack;
    longint t0;
    t0 = cycCnt;
    polls = 0;
    do begin
      i2cStart();
      sendByte(devByte(1'b0), ack);
      i2cStop();
      polls++;
    end while (!ack && polls < 50);
    cycles = cycCnt - t0;
  endtask

  task automatic randRead(input logic [15:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    logic [MEM_AW-1:0] base;
    base = a[MEM_AW-1:0];
    i2cStart();
    sendByte(devByte(1'b0), ack);
    sendByte(a[15:8], ack);
    sendByte(a[7:0], ack);
    i2cStart();
    sendByte(devByte(1'b1), ack);
    chk("R8 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      chk(tag, b, model[MEM_AW'(int'(base) + k)]);
    end
    chk("R9 data line released after NACK", sdaPullLow, 0);
    i2cStop();
    modelPtr = MEM_AW'(int'(base) + n);
  endtask

  task automatic curRead(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    i2cStart();
    sendByte(devByte(1'b1), ack);
    chk("R8 current read ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      chk(tag, b, model[MEM_AW'(int'(modelPtr) + k)]);
    end
    i2cStop();
    modelPtr = MEM_AW'(int'(modelPtr) + n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    int polls;
    longint cycles;
    logic [15:0] a;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 data line released after reset", sdaPullLow, 0);
    randRead(16'h0155, 2, "R10 erased after reset");

    // R1: foreign type code, then ignored until STOP; wrong straps
    i2cStart();
    sendByte(8'b1011_1010, ack);
    chk("R1 foreign type code not acked", ack, 0);
    sendByte(devByte(1'b0), ack);
    chk("R1 ignored until START or STOP", ack, 0);
    i2cStop();
    i2cStart();
    sendByte({4'b1010, 3'b010, 1'b0}, ack);
    chk("R1 strap mismatch not acked", ack, 0);
    i2cStop();

    // R4, R5, R6: byte write with polling
    wrBuf[0] = 8'hA5;
    doWrite(16'h0123, 1);
    waitReady(polls, cycles);
    chk("R6 first poll during cycle not acked", polls > 1, 1);
    chk("R5 cycle not shorter than WR_CYCLES", cycles >= WR_CYC, 1);
    chk("R5 cycle ends within one poll", cycles <= WR_CYC + 400, 1);
    randRead(16'h0122, 3, "R4 byte write neighbours");

    // R2: high word address bits ignored
    wrBuf[0] = 8'h3C;
    doWrite(16'h8200, 1);
    waitReady(polls, cycles);
    randRead(16'h0200, 1, "R2 upper address bits ignored");

    // R3: page wrap
    for (int k = 0; k < 10; k++) wrBuf[k] = 8'h40 + 8'(k);
    doWrite(16'h007C, 10);
    waitReady(polls, cycles);
    curRead(1, "R8 current read after page write");
    randRead(16'h0000, 8, "R3 wrapped bytes at page start");
    randRead(16'h007C, 5, "R3 page tail and next page untouched");

    // R7: write protect
    wpM = 1'b1;
    wrBuf[0] = 8'h77;
    doWrite(16'h0300, 1);
    waitReady(polls, cycles);
    chk("R7 no busy period when protected", polls, 1);
    wpM = 1'b0;
    randRead(16'h0300, 1, "R7 protected byte unchanged");

    // R9: sequential read across the top of the array
    randRead(16'(MEM_BYTES - 2), 4, "R9 sequential wrap to zero");
    curRead(2, "R8 current read after sequential read");

    // random mix
    for (int it = 0; it < 12; it++) begin
      a = 16'($urandom);
      n = 1 + int'($urandom % 8);
      wpM = ($urandom % 4) == 0;
      for (int k = 0; k < n; k++) wrBuf[k] = 8'($urandom);
      doWrite(a, n);
      waitReady(polls, cycles);
      if (wpM) chk("R7 random protected write no busy", polls, 1);
      else     chk("R6 random write busy polls", polls > 1, 1);
      wpM = 1'b0;
      randRead(a - 16'd1, n + 2, "R3 random readback");
      curRead(2, "R8 random current read");
    end

    chk("R11 pull changes only with clock low", oeViol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule